// File: doc/BRIEF.md
# Delayed-Quotient Word-Serial Montgomery Multiplier

This block computes a Montgomery product of two wide unsigned operands that are split into k-bit words. A row of identical processing elements (PEs), one for each word position, accumulates one multiplier word per clock. Each PE forms two k-by-k products and adds the partial-sum word of its upper neighbour and its own carry word. The quotient digit for a step is the least significant sum word that was registered d steps earlier, so finding a quotient needs neither a multiplication nor any logic ahead of the array. The modulus input takes a pre-scaled image of the true modulus. Because of that scaling, the delayed quotients still make every step exactly divisible.

The result is left in redundant form: one k-bit sum word and one (k+2)-bit carry word per PE. A separate carry-resolving adder downstream turns it into a plain integer. A one-cycle `start` captures the operands, and a one-cycle `done` marks the result as valid. The result then stays unchanged until the next accepted start.

Top module: `qpipe_montmul`

## Requirements
- R1: For an odd true modulus M, let Mq = (-M^-1) mod 2^(K*(D+1)), and drive `opModImg` with Mp = (M*Mq + 1) / 2^(K*(D+1)). The resolved result X then satisfies X * 2^(K*(NW+D)) ≡ A*B (mod M).
- R2: X equals the following recurrence exactly. Start with S = 0 and all quotients zero. For i = 0 .. NW+D: q_i = S mod 2^K, then S = floor(S / 2^K) + q_(i-D)*Mp + b_i*A, where b_i is word i of B and b_i = 0 for i >= NW. Finally X = S + Mp * sum over u = 1..D of q_(NW+D+1-u) * 2^(K*(D+1-u)).
- R3: X = sum over j of resSum[K*j +: K]*2^(K*j) + resCarry[(K+2)*j +: K+2]*2^(K*(j+1)), for PE index j = 0 .. NW+D+1. The carry field of the top PE is zero whenever `done` is high.
- R4: `done` is high for exactly one cycle. It is sampled high on the rising edge that comes NW+2D+2 edges after the edge that accepted `start`, counting that accepting edge as the first.
- R5: A `start` that arrives while a product is in progress is ignored. The running product keeps its result and its `done` timing.
- R6: The operands are captured on the edge that accepts `start`. Later changes on `opA`, `opB` or `opModImg` do not affect the result.
- R7: After `done`, `resSum` and `resCarry` keep their values until the next accepted `start`.
- R8: While `rst` is high and after its release, `done` is low and every result word is zero until a product completes.
- R9: The result is correct at the boundary cases: a zero operand, all-ones operands larger than the modulus, and a modulus only a few bits wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a product; accepted only when idle |
| opA | input | NW*K | Multiplicand, word j at bits K*j +: K |
| opB | input | NW*K | Multiplier, consumed one word per step from word 0 up |
| opModImg | input | NW*K | Pre-scaled modulus image Mp |
| done | output | 1 | One-cycle pulse when the result is valid |
| resSum | output | (NW+D+2)*K | Sum word of each PE |
| resCarry | output | (NW+D+2)*(K+2) | Carry word of each PE, weighted one word above its sum word |

## Verification
The hardest state to reach from the ports is the end of a product, where the D delayed quotients are still pending and the array must fold them in through its shifted-modulus passes. An error there only appears when the last quotients are nonzero and of various sizes. To get there, the vector table mixes dense operands, operands larger than the modulus and a very small modulus, so that the final low words vary widely. Each resolved result is compared with an exact model of the recurrence and also checked against the modular congruence. A second start, with scrambled operands, is injected in the middle of a running product to show that neither the captured operands nor the schedule move.

// File: rtl/qmm_pkg.sv
package qmm_pkg;
  // Width of the step and shift index fields carried from control to datapath.
  localparam int IDX_W = 8;

  typedef struct packed {
    logic             load;      // capture operands and clear the array
    logic             step;      // reduction step: divide by 2^K and accumulate
    logic             flush;     // fold one pending quotient, no division
    logic [IDX_W-1:0] bIdx;      // multiplier word used in this step
    logic [IDX_W-1:0] shiftAmt;  // modulus word offset for the fold pass
  } qmmStrobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FLUSH} qmmState_t;
endpackage

// File: rtl/qmm_pe.sv
module qmm_pe #(
  parameter int K  = 16,
  parameter int CW = K + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic          flush,
  input  logic [K-1:0]  aWord,
  input  logic [K-1:0]  bWord,
  input  logic [K-1:0]  qWord,
  input  logic [K-1:0]  mWord,
  input  logic [K-1:0]  sAbove,
  input  logic [CW-1:0] cBelow,
  output logic [K-1:0]  sOut,
  output logic [CW-1:0] cOut
);
  localparam int TW = 2 * K + 2;

  logic [K-1:0]  sReg;
  logic [CW-1:0] cReg;
  logic [TW-1:0] prodA, prodQ, addS, addC, total;

  always_comb begin
    prodA = step ? TW'(aWord) * TW'(bWord) : '0;
    prodQ = TW'(qWord) * TW'(mWord);
    // A step shifts the sum down one word; the own carry already sits at that weight.
    // A fold pass keeps positions, so the carry comes from the lower neighbour.
    addS  = step ? TW'(sAbove) : TW'(sReg);
    addC  = step ? TW'(cReg)   : TW'(cBelow);
    total = prodA + prodQ + addS + addC;
  end

  always_ff @(posedge clk) begin
    if (rst || load) begin
      sReg <= '0;
      cReg <= '0;
    end else if (step || flush) begin
      sReg <= total[K-1:0];
      cReg <= total[TW-1:K];
    end
  end

  assign sOut = sReg;
  assign cOut = cReg;
endmodule

// File: rtl/qmm_datapath.sv
module qmm_datapath
  import qmm_pkg::*;
#(
  parameter int K  = 16,
  parameter int NW = 4,
  parameter int D  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  qmmStrobe_t        strobe,
  input  logic [NW*K-1:0]   opA,
  input  logic [NW*K-1:0]   opB,
  input  logic [NW*K-1:0]   opModImg,
  output logic [(NW+D+2)*K-1:0]     resSum,
  output logic [(NW+D+2)*(K+2)-1:0] resCarry
);
  localparam int P  = NW + D + 2;
  localparam int CW = K + 2;

  logic [NW*K-1:0] aReg, bReg, mReg;
  logic [K-1:0]    qLine [D];
  logic [K-1:0]    qUse;
  logic [K-1:0]    bWord;
  logic [K-1:0]    mPad  [P+D];
  logic [K-1:0]    sWord [P];
  logic [CW-1:0]   cWord [P];

  always_ff @(posedge clk) begin
    if (rst) begin
      aReg <= '0;
      bReg <= '0;
      mReg <= '0;
    end else if (strobe.load) begin
      aReg <= opA;
      bReg <= opB;
      mReg <= opModImg;
    end
  end

  // Delay line of quotient digits: qLine[0] is the newest, qLine[D-1] is applied.
  always_ff @(posedge clk) begin
    if (rst || strobe.load) begin
      for (int i = 0; i < D; i++) qLine[i] <= '0;
    end else if (strobe.step || strobe.flush) begin
      qLine[0] <= strobe.step ? sWord[0] : '0;
      for (int i = 1; i < D; i++) qLine[i] <= qLine[i-1];
    end
  end
  assign qUse = qLine[D-1];

  always_comb begin
    bWord = '0;
    for (int x = 0; x < NW; x++)
      if (strobe.bIdx == IDX_W'(x)) bWord = bReg[x*K +: K];
  end

  // Modulus words padded with D zero words below and zeros above.
  for (genvar x = 0; x < P + D; x++) begin : g_mpad
    if (x >= D && x < D + NW) begin : g_word
      assign mPad[x] = mReg[(x-D)*K +: K];
    end else begin : g_zero
      assign mPad[x] = '0;
    end
  end

  for (genvar j = 0; j < P; j++) begin : g_pe
    logic [K-1:0]  aW, mSel, sUp;
    logic [CW-1:0] cLow;

    if (j < NW) begin : g_a
      assign aW = aReg[j*K +: K];
    end else begin : g_a0
      assign aW = '0;
    end

    if (j < P - 1) begin : g_up
      assign sUp = sWord[j+1];
    end else begin : g_up0
      assign sUp = '0;
    end

    if (j > 0) begin : g_lo
      assign cLow = cWord[j-1];
    end else begin : g_lo0
      assign cLow = '0;
    end

    always_comb begin
      mSel = '0;
      for (int t = 0; t <= D; t++)
        if (strobe.shiftAmt == IDX_W'(t)) mSel = mPad[j - t + D];
    end

    qmm_pe #(.K(K), .CW(CW)) u_pe (
      .clk   (clk),
      .rst   (rst),
      .load  (strobe.load),
      .step  (strobe.step),
      .flush (strobe.flush),
      .aWord (aW),
      .bWord (bWord),
      .qWord (qUse),
      .mWord (mSel),
      .sAbove(sUp),
      .cBelow(cLow),
      .sOut  (sWord[j]),
      .cOut  (cWord[j])
    );

    assign resSum[j*K +: K]     = sWord[j];
    assign resCarry[j*CW +: CW] = cWord[j];
  end
endmodule

// File: rtl/qmm_ctrl.sv
module qmm_ctrl
  import qmm_pkg::*;
#(
  parameter int NW = 4,
  parameter int D  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output qmmStrobe_t strobe,
  output logic       done
);
  localparam int NIT = NW + D + 1;

  qmmState_t        state;
  logic [IDX_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_RUN;
          cnt   <= '0;
        end
        ST_RUN: if (cnt == IDX_W'(NIT - 1)) begin
          state <= ST_FLUSH;
          cnt   <= IDX_W'(1);
        end else begin
          cnt <= cnt + 1'b1;
        end
        ST_FLUSH: if (cnt == IDX_W'(D)) begin
          state <= ST_IDLE;
          cnt   <= '0;
          done  <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.load     = (state == ST_IDLE) && start;
    strobe.step     = (state == ST_RUN);
    strobe.flush    = (state == ST_FLUSH);
    strobe.bIdx     = cnt;
    strobe.shiftAmt = (state == ST_FLUSH) ? cnt : '0;
  end
endmodule

// File: rtl/qpipe_montmul.sv
module qpipe_montmul
  import qmm_pkg::*;
#(
  parameter int K  = 16,
  parameter int NW = 4,
  parameter int D  = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic [NW*K-1:0]               opA,
  input  logic [NW*K-1:0]               opB,
  input  logic [NW*K-1:0]               opModImg,
  output logic                          done,
  output logic [(NW+D+2)*K-1:0]         resSum,
  output logic [(NW+D+2)*(K+2)-1:0]     resCarry
);
  qmmStrobe_t strobe;

  qmm_ctrl #(.NW(NW), .D(D)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .strobe(strobe),
    .done  (done)
  );

  qmm_datapath #(.K(K), .NW(NW), .D(D)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .opA     (opA),
    .opB     (opB),
    .opModImg(opModImg),
    .resSum  (resSum),
    .resCarry(resCarry)
  );
endmodule

// File: rtl/qpipe_montmul_chk.sv
module qpipe_montmul_chk #(
  parameter int K  = 16,
  parameter int NW = 4,
  parameter int D  = 2
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      start,
  input logic                      done,
  input logic [(NW+D+2)*K-1:0]     resSum,
  input logic [(NW+D+2)*(K+2)-1:0] resCarry
);
  localparam int P   = NW + D + 2;
  localparam int CW  = K + 2;
  localparam int LAT = NW + 2 * D + 1;

  logic        busyC;
  logic [15:0] cnt;

  // Independent view of the schedule, seen only from the ports.
  always_ff @(posedge clk) begin
    if (rst) begin
      busyC <= 1'b0;
      cnt   <= '0;
    end else if ((!busyC || done) && start) begin
      busyC <= 1'b1;
      cnt   <= '0;
    end else if (done) begin
      busyC <= 1'b0;
    end else if (busyC) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R4 and R5: done comes only at the fixed distance from the accepted start.
  assert_done_timing_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> (busyC && cnt == 16'(LAT)));

  // R4: done lasts one cycle.
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3: the top carry field never holds weight beyond the array.
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> (resCarry[(P-1)*CW +: CW] == '0));

  // R7: an idle block without a start keeps its result.
  assert_result_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!busyC && !start) |=> ($stable(resSum) && $stable(resCarry)));

  // R8: reset clears the pulse and the result.
  assert_reset_state_R8: assert property (@(posedge clk)
    rst |=> (!done && resSum == '0 && resCarry == '0));
endmodule

bind qpipe_montmul qpipe_montmul_chk #(.K(K), .NW(NW), .D(D)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .done    (done),
  .resSum  (resSum),
  .resCarry(resCarry)
);

// File: tb/sim_qpipe_montmul.sv
`timescale 1ns/1ps
module sim_qpipe_montmul;
  localparam int K   = 16;
  localparam int NW  = 4;
  localparam int D   = 2;
  localparam int P   = NW + D + 2;
  localparam int CW  = K + 2;
  localparam int NIT = NW + D + 1;
  localparam int LAT = NW + 2 * D + 2;
  localparam int RSH = K * (NW + D);
  localparam int QB  = K * (D + 1);
  localparam int NV  = 6;

  // Each entry: {A, B, true modulus M}
  localparam logic [191:0] VEC [NV] = '{
    {64'h0123456789ABCDEF, 64'h0FEDCBA987654321, 64'hFFFFFFFFFFFFFFC5},
    {64'h0000000000000000, 64'h0000000123456789, 64'hFFFFFFFFFFFFFFC5},
    {64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 64'h8000000000000001},
    {64'h0000000000000001, 64'h0000000000000001, 64'h00000000000000C5},
    {64'hDEADBEEFCAFEF00D, 64'h0000000000000000, 64'h1000000000000001},
    {64'h0000FFFF0000FFFF, 64'hFFFF0000FFFF0000, 64'hC000000000000003}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [NW*K-1:0] opA = '0, opB = '0, opModImg = '0;
  logic done;
  logic [P*K-1:0]  resSum;
  logic [P*CW-1:0] resCarry;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  qpipe_montmul #(.K(K), .NW(NW), .D(D)) u0 (
    .clk(clk), .rst(rst), .start(start), .opA(opA), .opB(opB),
    .opModImg(opModImg), .done(done), .resSum(resSum), .resCarry(resCarry)
  );

  task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] scaleMod(input logic [255:0] m);
    logic [255:0] mask, x, mq;
    mask = (256'd1 << QB) - 1;
    x = m;
    for (int i = 0; i < 6; i++) x = (x * (256'd2 - m * x)) & mask;
    mq = ((256'd1 << QB) - x) & mask;
    return (m * mq + 256'd1) >> QB;
  endfunction

  function automatic logic [255:0] refModel(input logic [255:0] a, input logic [255:0] b, input logic [255:0] mp);
    logic [255:0] s, qh [NIT], qOld, bw, mask;
    mask = (256'd1 << K) - 1;
    s = '0;
    for (int i = 0; i < NIT; i++) begin
      qh[i] = s & mask;
      qOld  = (i >= D) ? qh[i-D] : '0;
      bw    = (i < NW) ? ((b >> (K*i)) & mask) : '0;
      s     = (s >> K) + qOld * mp + bw * a;
    end
    for (int u = 1; u <= D; u++) s = s + ((mp * qh[NIT-u]) << (K*(D+1-u)));
    return s;
  endfunction

  function automatic logic [255:0] resolve();
    logic [255:0] x;
    x = '0;
    for (int j = 0; j < P; j++) begin
      x = x + (256'(resSum[j*K +: K]) << (K*j));
      x = x + (256'(resCarry[j*CW +: CW]) << (K*(j+1)));
    end
    return x;
  endfunction

  // mode 0: clean run; 1: operands change mid-run; 2: change plus a second start
  task automatic runOp(input logic [63:0] a, input logic [63:0] b, input logic [63:0] mp,
                       input int mode, output logic [255:0] x, output int lat);
    @(negedge clk);
    opA = a; opB = b; opModImg = mp; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 60) begin
      if (lat == 3 && mode != 0) begin
        opA = ~a; opB = b ^ 64'h5555AAAA5555AAAA; opModImg = mp ^ 64'h10;
        if (mode == 2) start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(posedge clk); @(negedge clk);
      lat++;
    end
    start = 1'b0;
    x = resolve();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [255:0] x, xRef, mTrue, mp, a, b, x0;
    int lat;

    // R8: reset state
    repeat (3) @(negedge clk);
    check(!done && resSum == '0 && resCarry == '0, "R8 during reset", 256'(resSum), '0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(!done && resSum == '0 && resCarry == '0, "R8 after reset", 256'(resSum), '0);

    for (int v = 0; v < NV; v++) begin
      a = 256'(VEC[v][191:128]);
      b = 256'(VEC[v][127:64]);
      mTrue = 256'(VEC[v][63:0]);
      mp = scaleMod(mTrue);
      runOp(a[63:0], b[63:0], mp[63:0], 0, x, lat);
      xRef = refModel(a, b, mp);
      check(x == xRef, "R2 exact recurrence value", x, xRef);
      check(((x << RSH) % mTrue) == ((a * b) % mTrue), "R1 R9 Montgomery congruence",
            (x << RSH) % mTrue, (a * b) % mTrue);
      check(lat == LAT, "R4 done latency", 256'(lat), 256'(LAT));
      check(resCarry[(P-1)*CW +: CW] == '0, "R3 top carry zero", 256'(resCarry[(P-1)*CW +: CW]), '0);
      @(negedge clk);
      check(!done, "R4 done one cycle", 256'(done), '0);
    end

    // R7: result held while idle, inputs moving
    a = 256'(VEC[0][191:128]); b = 256'(VEC[0][127:64]); mTrue = 256'(VEC[0][63:0]);
    mp = scaleMod(mTrue);
    runOp(a[63:0], b[63:0], mp[63:0], 0, x0, lat);
    opA = '1; opB = 64'h1234; opModImg = 64'h77;
    repeat (6) @(negedge clk);
    x = resolve();
    check(x == x0, "R7 result held", x, x0);

    // R6: operands change after capture
    xRef = refModel(a, b, mp);
    runOp(a[63:0], b[63:0], mp[63:0], 1, x, lat);
    check(x == xRef, "R6 operands captured at start", x, xRef);

    // R5: second start while busy
    runOp(a[63:0], b[63:0], mp[63:0], 2, x, lat);
    check(x == xRef, "R5 busy start ignored value", x, xRef);
    check(lat == LAT, "R5 busy start ignored timing", 256'(lat), 256'(LAT));
    repeat (LAT + 2) begin
      @(negedge clk);
      check(!done, "R5 no extra done", 256'(done), '0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule